// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block executes the string I/O transfers of an 8-bit processor core. It moves bytes between an I/O port and memory, one byte per iteration. The core's decoder hands it the second byte of an `ED`-prefixed opcode, together with the current address register (HL), count register (B), port register (C) and flag byte. The sequencer then runs the transfer on two request/ready channels, one to memory and one to the I/O space. It returns the updated registers, the flags and the number of T-states the instruction consumed.

A transfer is either input (port to memory) or output (memory to port). It steps HL up or down and always decrements B. The repeating forms loop on their own until B reaches zero. Each channel uses a valid/ready rule: a request (`io_req` or `mem_req`) stays asserted with its address, write enable and write data unchanged until the responder raises the matching ready. The transfer happens in the cycle where request and ready are both high, and read data is taken in that same cycle. A slow responder stalls the sequencer and drops no byte. At most one request is outstanding across both channels.

Top module: `blkio_seq`

## Requirements
- R1: `start` is taken only while idle and only for the opcodes A2, A3, AA, AB, B2, B3, BA and BB. Their decoding is fixed: bit0 = 1 means output (memory to port), bit3 = 1 means decrement HL, and bit4 = 1 means repeat. A `start` with any other code, or any `start` while busy, changes no register and issues no request.
- R2: An input transfer issues an I/O read at address {B,C}, using B before its decrement. It then issues a memory write of the byte it read to address HL.
- R3: An output transfer issues a memory read at HL. It then issues an I/O write of that byte to address {B,C}, using B before its decrement.
- R4: On each completed write, B decreases by 1 modulo 256, and HL steps by +1 or -1 modulo 65536. C never changes.
- R5: A repeating form starts a new iteration while B is non-zero after the decrement. A starting B of 0 therefore gives 256 transfers.
- R6: The flag byte uses S = bit7, Z = bit6, H = bit4, P/V = bit2, N = bit1 and C = bit0. After each byte, Z = (B == 0) and N = 1. S, H, P/V, C and the unused bits 5 and 3 keep their loaded values.
- R7: `tstates` is the total of the instruction. A single form costs 16. Each iteration of a repeating form costs 21 when B is non-zero afterwards and 16 when it reaches zero.
- R8: `done` is high for exactly one cycle, the cycle after the final write completes. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R9: A request held without ready keeps its address, write enable and write data stable. `io_req` and `mem_req` are never high together.
- R10: After reset the block is idle: no request, `done` low, and registers, flags and `tstates` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (one-cycle pulse) |
| op_code | input | 8 | Opcode byte following the ED prefix |
| hl_in | input | 16 | Initial HL |
| b_in | input | 8 | Initial B |
| c_in | input | 8 | Initial C |
| flags_in | input | 8 | Initial flag byte |
| io_req | output | 1 | I/O request valid |
| io_we | output | 1 | I/O request is a write |
| io_addr | output | 16 | I/O port address {B,C} |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, valid with io_ready |
| io_ready | input | 1 | I/O responder accepts the request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory address (HL) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory responder accepts the request |
| hl_out | output | 16 | Current HL |
| b_out | output | 8 | Current B |
| c_out | output | 8 | Current C |
| flags_out | output | 8 | Current flag byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| tstates | output | 16 | T-states of the current or last instruction |

## Verification
The hardest case to reach is a repeating transfer that starts with B = 0. It has to run all 256 iterations, charge 21 T-states for each of them except the last, and wrap HL across the ends of the address space. The bench starts a decrementing output loop with B = 0 and HL just above zero. It also starts an incrementing input loop with HL just below the top. Both runs use back-pressure that alternates, or that stalls two cycles in three, so every request is held while it waits. A stray `start` is injected in the middle of a repeating run, and the bench checks that the run's transfer stream and totals stay unchanged.

// File: rtl/blkio_pkg.sv
package blkio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE, ST_FIN} seq_state_t;

  typedef struct packed {
    logic to_port;   // 1: memory -> port
    logic down;      // 1: HL decrements
    logic again;     // 1: auto-repeat
  } xfer_cmd_t;

  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;
endpackage

// File: rtl/blkio_decode.sv
module blkio_decode
  import blkio_pkg::*;
(
  input  logic [7:0] op,
  output logic       op_ok,
  output xfer_cmd_t  cmd
);
  // Family of string I/O codes: 101x_x01x
  always_comb begin
    op_ok       = (op[7:5] == 3'b101) && (op[2:1] == 2'b01);
    cmd.to_port = op[0];
    cmd.down    = op[3];
    cmd.again   = op[4];
  end
endmodule

// File: rtl/blkio_ctrl.sv
module blkio_ctrl
  import blkio_pkg::*;
#(
  parameter int TW       = 16,
  parameter int T_SINGLE = 16,
  parameter int T_REPEAT = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_ok,
  input  xfer_cmd_t     cmd_in,
  input  logic          io_ready,
  input  logic          mem_ready,
  input  logic          b_last,
  output logic          load,
  output logic          cap,
  output logic          step,
  output xfer_cmd_t     cmd_q,
  output logic          io_req,
  output logic          io_we,
  output logic          mem_req,
  output logic          mem_we,
  output logic          busy,
  output logic          done,
  output logic [TW-1:0] tstates
);
  localparam logic [TW-1:0] COST_RPT = TW'(T_REPEAT);
  localparam logic [TW-1:0] COST_END = TW'(T_SINGLE);

  seq_state_t state_q, state_d;
  logic       hs, more;

  always_comb begin
    load    = (state_q == ST_IDLE) && start && op_ok;
    io_req  = ((state_q == ST_FETCH) && !cmd_q.to_port) ||
              ((state_q == ST_STORE) &&  cmd_q.to_port);
    mem_req = ((state_q == ST_FETCH) &&  cmd_q.to_port) ||
              ((state_q == ST_STORE) && !cmd_q.to_port);
    io_we   = io_req  && (state_q == ST_STORE);
    mem_we  = mem_req && (state_q == ST_STORE);
    hs      = (io_req && io_ready) || (mem_req && mem_ready);
    cap     = (state_q == ST_FETCH) && hs;
    step    = (state_q == ST_STORE) && hs;
    more    = cmd_q.again && !b_last;
    busy    = (state_q != ST_IDLE);
    done    = (state_q == ST_FIN);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (load) state_d = ST_FETCH;
      ST_FETCH: if (cap)  state_d = ST_STORE;
      ST_STORE: if (step) state_d = more ? ST_FETCH : ST_FIN;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      tstates <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        cmd_q   <= cmd_in;
        tstates <= '0;
      end else if (step) begin
        tstates <= tstates + (more ? COST_RPT : COST_END);
      end
    end
  end

  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && mem_req));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_io_held: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_ready) |=> (io_req && $stable(io_we)));
  a_r9_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));
  a_r1_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
  a_r7_total_floor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tstates >= COST_END));
endmodule

// File: rtl/blkio_regs.sv
module blkio_regs
  import blkio_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] hl_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  input  logic [7:0]    f_in,
  input  logic          cap,
  input  logic [DW-1:0] rd_byte,
  input  logic          step,
  input  logic          down,
  output logic [AW-1:0] hl_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] c_q,
  output logic [7:0]    f_q,
  output logic [DW-1:0] data_q,
  output logic          b_last
);
  assign b_last = (b_q == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl_q   <= '0;
      b_q    <= '0;
      c_q    <= '0;
      f_q    <= '0;
      data_q <= '0;
    end else if (load) begin
      hl_q <= hl_in;
      b_q  <= b_in;
      c_q  <= c_in;
      f_q  <= f_in;
    end else begin
      if (cap) data_q <= rd_byte;
      if (step) begin
        b_q       <= b_q - DW'(1);
        hl_q      <= down ? (hl_q - AW'(1)) : (hl_q + AW'(1));
        f_q[FL_Z] <= b_last;
        f_q[FL_N] <= 1'b1;
      end
    end
  end

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (b_q == $past(b_q) - DW'(1)));
  a_r4_hl_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down) |=> (hl_q == $past(hl_q) + AW'(1)));
  a_r4_hl_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down) |=> (hl_q == $past(hl_q) - AW'(1)));
  a_r4_port_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(c_q));
  a_r6_n_set: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> f_q[FL_N]);
  a_r6_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (f_q[FL_S] == $past(f_q[FL_S]) && f_q[FL_H] == $past(f_q[FL_H]) &&
               f_q[FL_PV] == $past(f_q[FL_PV]) && f_q[FL_C] == $past(f_q[FL_C])));
endmodule

// File: rtl/blkio_seq.sv
module blkio_seq
  import blkio_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int TW       = 16,
  parameter int T_SINGLE = 16,
  parameter int T_REPEAT = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      op_code,
  input  logic [AW-1:0]   hl_in,
  input  logic [DW-1:0]   b_in,
  input  logic [DW-1:0]   c_in,
  input  logic [7:0]      flags_in,
  output logic            io_req,
  output logic            io_we,
  output logic [2*DW-1:0] io_addr,
  output logic [DW-1:0]   io_wdata,
  input  logic [DW-1:0]   io_rdata,
  input  logic            io_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [AW-1:0]   hl_out,
  output logic [DW-1:0]   b_out,
  output logic [DW-1:0]   c_out,
  output logic [7:0]      flags_out,
  output logic            busy,
  output logic            done,
  output logic [TW-1:0]   tstates
);
  logic          op_ok, load, cap, step, b_last;
  xfer_cmd_t     cmd_dec, cmd_q;
  logic [DW-1:0] rd_byte, data_q;

  blkio_decode u_decode (
    .op    (op_code),
    .op_ok (op_ok),
    .cmd   (cmd_dec)
  );

  blkio_ctrl #(
    .TW       (TW),
    .T_SINGLE (T_SINGLE),
    .T_REPEAT (T_REPEAT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_ok     (op_ok),
    .cmd_in    (cmd_dec),
    .io_ready  (io_ready),
    .mem_ready (mem_ready),
    .b_last    (b_last),
    .load      (load),
    .cap       (cap),
    .step      (step),
    .cmd_q     (cmd_q),
    .io_req    (io_req),
    .io_we     (io_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .tstates   (tstates)
  );

  assign rd_byte = cmd_q.to_port ? mem_rdata : io_rdata;

  blkio_regs #(
    .AW (AW),
    .DW (DW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .hl_in   (hl_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .f_in    (flags_in),
    .cap     (cap),
    .rd_byte (rd_byte),
    .step    (step),
    .down    (cmd_q.down),
    .hl_q    (hl_out),
    .b_q     (b_out),
    .c_q     (c_out),
    .f_q     (flags_out),
    .data_q  (data_q),
    .b_last  (b_last)
  );

  assign io_addr   = {b_out, c_out};
  assign io_wdata  = data_q;
  assign mem_addr  = hl_out;
  assign mem_wdata = data_q;

  a_r9_io_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_ready) |=> ($stable(io_addr) && $stable(io_wdata)));
  a_r9_mem_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));
  a_r5_final_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[FL_Z] == (b_out == '0)));
endmodule

// File: tb/blkio_seq_tb.sv
module blkio_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start;
  logic [7:0]  op_code, b_in, c_in, flags_in;
  logic [15:0] hl_in;
  logic        io_req, io_we, io_ready, mem_req, mem_we, mem_ready;
  logic [15:0] io_addr, mem_addr, hl_out, tstates;
  logic [7:0]  io_wdata, io_rdata, mem_wdata, mem_rdata, b_out, c_out, flags_out;
  logic        busy, done;

  blkio_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .hl_in(hl_in), .b_in(b_in), .c_in(c_in), .flags_in(flags_in),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_ready(io_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .hl_out(hl_out), .b_out(b_out), .c_out(c_out), .flags_out(flags_out),
    .busy(busy), .done(done), .tstates(tstates)
  );

  function automatic logic [7:0] port_val(logic [15:0] a);
    return (a[7:0] + 8'h33) ^ a[15:8];
  endfunction
  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  assign io_rdata  = port_val(io_addr);
  assign mem_rdata = mem_val(mem_addr);

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy(int mode, int n);
    case (mode)
      0:       return 1'b1;
      1:       return n[0];
      default: return (n % 3) == 2;
    endcase
  endfunction

  // expected transaction stream
  bit          q_io[$];
  bit          q_we[$];
  logic [15:0] q_addr[$];
  logic [7:0]  q_data[$];

  task automatic run(logic [7:0] op, logic [15:0] hl0, logic [7:0] b0, logic [7:0] c0,
                     logic [7:0] f0, int mode, bit stray, string req);
    bit          to_port = op[0];
    bit          down    = op[3];
    bit          again   = op[4];
    logic [15:0] hl = hl0;
    logic [7:0]  b  = b0;
    logic [7:0]  fx;
    int          tot = 0;
    bit          fin = 0;
    q_io.delete(); q_we.delete(); q_addr.delete(); q_data.delete();
    do begin
      if (!to_port) begin
        q_io.push_back(1); q_we.push_back(0); q_addr.push_back({b, c0}); q_data.push_back(8'h0);
        q_io.push_back(0); q_we.push_back(1); q_addr.push_back(hl); q_data.push_back(port_val({b, c0}));
      end else begin
        q_io.push_back(0); q_we.push_back(0); q_addr.push_back(hl); q_data.push_back(8'h0);
        q_io.push_back(1); q_we.push_back(1); q_addr.push_back({b, c0}); q_data.push_back(mem_val(hl));
      end
      b  = b - 8'd1;
      hl = down ? hl - 16'd1 : hl + 16'd1;
      tot += (again && b != 0) ? 21 : 16;
    end while (again && b != 0);
    fx = f0;
    fx[6] = (b == 0);
    fx[1] = 1'b1;

    @(negedge clk);
    op_code = op; hl_in = hl0; b_in = b0; c_in = c0; flags_in = f0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      io_ready  = rdy(mode, n);
      mem_ready = rdy(mode, n + 1);
      start     = stray && (n == 5);
      op_code   = stray ? 8'hA3 : op;
      if (done) begin
        chk(q_io.size() == 0, "R5", "transfers left at done", q_io.size(), 0);
        chk(hl_out == hl, "R4", "HL at end", hl_out, hl);
        chk(b_out == b, "R4", "B at end", b_out, b);
        chk(c_out == c0, "R4", "C at end", c_out, c0);
        chk(flags_out == fx, "R6", "flags at end", flags_out, fx);
        chk(tstates == 16'(tot), "R7", "T-state total", tstates, tot);
        chk(busy, "R8", "busy during done", busy, 1);
        fin = 1;
        break;
      end
      chk(busy, "R8", "busy while running", busy, 1);
      chk(!(io_req && mem_req), "R9", "both channels requested", {io_req, mem_req}, 0);
      if (io_req || mem_req) begin
        if (q_io.size() == 0) begin
          chk(0, req, "request after last transfer", {io_req, mem_req}, 0);
        end else begin
          chk(io_req == q_io[0], q_io[0] ? "R2" : "R3", "channel", io_req, q_io[0]);
          chk((io_req ? io_we : mem_we) == q_we[0], req, "write enable",
              io_req ? io_we : mem_we, q_we[0]);
          chk((io_req ? io_addr : mem_addr) == q_addr[0], req, "address",
              io_req ? io_addr : mem_addr, q_addr[0]);
          if (q_we[0])
            chk((io_req ? io_wdata : mem_wdata) == q_data[0], req, "write data",
                io_req ? io_wdata : mem_wdata, q_data[0]);
          if ((io_req && io_ready) || (mem_req && mem_ready)) begin
            void'(q_io.pop_front()); void'(q_we.pop_front());
            void'(q_addr.pop_front()); void'(q_data.pop_front());
          end
        end
      end
      @(negedge clk);
    end
    if (!fin) chk(0, req, "watchdog expired", 0, 1);
    start = 1'b0; io_ready = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8", "idle after done", {done, busy}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_code = 8'h00; hl_in = '0; b_in = '0; c_in = '0;
    flags_in = '0; io_ready = 1'b0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !io_req && !mem_req, "R10", "idle after reset",
        {busy, done, io_req, mem_req}, 0);
    chk(hl_out == 0 && b_out == 0 && flags_out == 0 && tstates == 0, "R10",
        "registers after reset", {hl_out, b_out, flags_out}, 0);

    run(8'hA2, 16'h1000, 8'h05, 8'h40, 8'h00, 0, 0, "R2");   // single input, up
    run(8'hAA, 16'h2000, 8'h01, 8'h41, 8'hD5, 1, 0, "R2");   // single input, down, B->0
    run(8'hA3, 16'hFFFF, 8'h09, 8'h7E, 8'h95, 2, 0, "R3");   // single output, HL wrap up
    run(8'hAB, 16'h0000, 8'h02, 8'h10, 8'h40, 1, 0, "R3");   // single output, HL wrap down
    run(8'hB2, 16'hFFFE, 8'h03, 8'h22, 8'h01, 1, 0, "R5");   // repeat input, HL wraps
    run(8'hBA, 16'h3000, 8'h01, 8'h23, 8'h94, 0, 0, "R7");   // repeat, one pass
    run(8'hB3, 16'h4000, 8'h04, 8'h55, 8'h14, 2, 1, "R1");   // repeat output, stray start
    run(8'hBB, 16'h0080, 8'h00, 8'h66, 8'h85, 1, 0, "R5");   // B=0: 256 passes

    // R1: code outside the family must not start anything
    @(negedge clk);
    op_code = 8'hA4; hl_in = 16'h1234; b_in = 8'h07; c_in = 8'h01; flags_in = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !io_req && !mem_req, "R1", "unknown code started", {busy, io_req, mem_req}, 0);
    chk(hl_out == 16'hFF80 && b_out == 8'h00 && c_out == 8'h66, "R1",
        "registers after unknown code", hl_out, 16'hFF80);
    chk(tstates == 16'd5371, "R1", "total after unknown code", tstates, 5371);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    fails++;
    checks++;
    $display("FAIL R8 global watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule